// File: doc/BRIEF.md
# Unified Translation Buffer with Rotating Load Slot

This block holds the shared, fully associative page-translation array of a processor core. The default build has 64 entries. Each entry carries a virtual page tag, an address-space tag, a physical page number, a 9-bit flag word and a 4-bit attribute nibble. Pages can be 1 KB, 4 KB, 64 KB or 1 MB, and an entry may be marked as shared so that it matches under any address space.

Two lookup ports serve the core: one for data accesses and one for instruction-buffer refills. Each returns hit plus entry index, miss, or multi-hit one clock later. Software fills entries in two ways. It can stage a page-table entry in three holding registers and issue a load, which writes the slot named by a rotating replacement pointer. It can also write the address or data half of a chosen slot directly. An associative form of the address write finds the entry matching a given page under the current address space and rewrites only its valid and dirty bits.

A control word exposes the replacement pointer, the boundary at which it wraps, and a 6-bit replacement state kept on behalf of the instruction buffer. Setting the invalidate bit clears every entry and pulses a flush request to the instruction buffer.

Top module: `xlat_utlb`

## Requirements
- R1: After reset every entry is invalid, the pointer, boundary and instruction-buffer state read as zero, and all result outputs and the read-data output are zero.
- R2: The control word reads the pointer at bits 15:10, the boundary at bits 23:18 and the instruction-buffer state at bits 31:26, with all other bits zero. A control write loads all three fields from the same positions.
- R3: A control write with bit 2 set clears the valid flag of every entry and raises `itlb_flush` for the following cycle.
- R4: The staging registers keep only these bits: the high word masked to 0xFFFFFCFF (current address-space tag in bits 7:0), the low word masked to 0x1FFFFDFF, and the attribute as 4 bits. A load writes tag = high[31:10], address space = high[7:0], physical page = low[28:10], flags = low[8:0] and the attribute into the slot at the pointer, and it leaves the pointer unchanged.
- R5: A direct address-array write (data select low, address bit 7 low) targets slot address[13:8]. It sets the tag from data[31:10], the address space from data[7:0], valid from data[8] and dirty from data[9]. An address-array read returns {tag, dirty, valid, address space} in bits 31:10, 9, 8 and 7:0.
- R6: A data-array access with address bit 23 set reads or writes only the attribute (bits 3:0). With bit 23 clear it reads or writes the physical page (bits 28:10) and flags (bits 8:0). Reads appear one cycle after the request.
- R7: The flag word holds valid at bit 8, shared at bit 1 and dirty at bit 2. An entry matches a lookup when it is valid, its address-space tag equals the current one or it is shared, and its masked tag equals the looked-up page. Results appear one cycle later, with exactly one of hit, miss or multi-hit raised per request.
- R8: Page size is flags {bit 7, bit 4}: 00 = 1 KB, 01 = 4 KB, 10 = 64 KB, 11 = 1 MB. Address bits below the page size are ignored in the match.
- R9: A lookup that matches two or more entries reports multi-hit.
- R10: Each lookup advances the pointer by one. The pointer returns to 0 when the advanced value equals the boundary or reaches the entry count.
- R11: The instruction-refill port applies the same match rule. When both ports look up in one cycle, the pointer advances twice, with the wrap rule applied at each step.
- R12: An associative address write (address bit 7 set) updates valid from data[8] and dirty from data[9] on the single entry matching data[31:10] under the current address space. If no entry matches, nothing changes.
- R13: If an associative address write matches more than one entry, no entry changes and `assoc_mhit` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback |
| itlb_flush | output | 1 | Pulse: instruction buffer must drop its entries |
| stg_we | input | 1 | Staging register write strobe |
| stg_sel | input | 2 | Staging target: 0 high, 1 low, 2 attribute |
| stg_wdata | input | 32 | Staging write data |
| load_cmd | input | 1 | Copy staging registers into the slot at the pointer |
| arr_we | input | 1 | Array write strobe |
| arr_re | input | 1 | Array read strobe |
| arr_data_sel | input | 1 | 1 selects data array, 0 address array |
| arr_addr | input | 32 | Array access address (slot, mode and half select) |
| arr_wdata | input | 32 | Array write data |
| arr_rdata | output | 32 | Array read data, one cycle after the read strobe |
| assoc_mhit | output | 1 | Associative write found multiple matches |
| dq_req | input | 1 | Data lookup request |
| dq_vpn | input | 32 | Data lookup virtual address |
| dq_hit | output | 1 | Data lookup single hit |
| dq_miss | output | 1 | Data lookup miss |
| dq_mhit | output | 1 | Data lookup multi-hit |
| dq_idx | output | IDX_W | Data lookup matching slot |
| iq_req | input | 1 | Instruction refill lookup request |
| iq_vpn | input | 32 | Instruction refill virtual address |
| iq_hit | output | 1 | Refill lookup single hit |
| iq_miss | output | 1 | Refill lookup miss |
| iq_mhit | output | 1 | Refill lookup multi-hit |
| iq_idx | output | IDX_W | Refill lookup matching slot |

## Verification
The bench builds the block with its default IDX_W of 6, which gives 64 entries and a 6-bit pointer and boundary. With that width, slot selection through address bits 13:8 covers its full range. Pointer positions 62 and 63 are reachable, so the wrap at the entry count can be exercised next to wraps at a programmed boundary. A smaller width would leave these control-word field positions partly empty.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef struct packed {
    logic [21:0] vpn;
    logic [7:0]  asid;
    logic [18:0] ppn;
    logic [8:0]  flags;
    logic [3:0]  attr;
  } tlb_ent_t;

  localparam int FL_SHARE = 1;
  localparam int FL_DIRTY = 2;
  localparam int FL_SZ_LO = 4;
  localparam int FL_SZ_HI = 7;
  localparam int FL_VALID = 8;
  localparam int CTL_INV  = 2;

  // mask over virtual address bits 31:10 for the page size in the flags
  function automatic logic [21:0] page_mask(input logic [8:0] fl);
    case ({fl[FL_SZ_HI], fl[FL_SZ_LO]})
      2'b00:   page_mask = 22'h3FFFFF;
      2'b01:   page_mask = 22'h3FFFFC;
      2'b10:   page_mask = 22'h3FFFC0;
      default: page_mask = 22'h3FFC00;
    endcase
  endfunction

endpackage

// File: rtl/xlat_cam_match.sv
module xlat_cam_match #(
  parameter int N = 64
) (
  input  xlat_pkg::tlb_ent_t [N-1:0] ents,
  input  logic [31:0]                vpn,
  input  logic [7:0]                 asid,
  output logic [N-1:0]               hits
);
  import xlat_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic space_ok;
    logic page_ok;
    assign space_ok = ents[i].flags[FL_SHARE] || (ents[i].asid == asid);
    assign page_ok  = ((ents[i].vpn ^ vpn[31:10]) & page_mask(ents[i].flags)) == 22'd0;
    assign hits[i]  = ents[i].flags[FL_VALID] && space_ok && page_ok;
  end

endmodule

// File: rtl/xlat_hit_enc.sv
module xlat_hit_enc #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0]  hits,
  output logic [IW-1:0] idx,
  output logic          any,
  output logic          multi
);

  always_comb begin
    idx   = '0;
    any   = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hits[i]) begin
        if (any) multi = 1'b1;
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/xlat_repl_ptr.sv
module xlat_repl_ptr #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_val,
  input  logic [IW-1:0] bound,
  input  logic [1:0]    adv,
  output logic [IW-1:0] ptr
);

  logic [IW-1:0] ptr_n;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p, input logic [IW-1:0] b);
    logic [IW:0] s;
    s = {1'b0, p} + (IW+1)'(1);
    if (s[IW] || (s[IW-1:0] == b)) return '0;
    return s[IW-1:0];
  endfunction

  always_comb begin
    ptr_n = ptr;
    if (ld_en) begin
      ptr_n = ld_val;
    end else begin
      case (adv)
        2'd1:    ptr_n = step(ptr, bound);
        2'd2:    ptr_n = step(step(ptr, bound), bound);
        default: ptr_n = ptr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_n;
  end

  // R10
  ptr_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv == 2'd1 && !ld_en) |=> ((ptr - $past(ptr)) == IW'(1)) || (ptr == '0));

endmodule

// File: rtl/xlat_utlb.sv
module xlat_utlb #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  output logic [31:0]      ctl_rdata,
  output logic             itlb_flush,
  input  logic             stg_we,
  input  logic [1:0]       stg_sel,
  input  logic [31:0]      stg_wdata,
  input  logic             load_cmd,
  input  logic             arr_we,
  input  logic             arr_re,
  input  logic             arr_data_sel,
  input  logic [31:0]      arr_addr,
  input  logic [31:0]      arr_wdata,
  output logic [31:0]      arr_rdata,
  output logic             assoc_mhit,
  input  logic             dq_req,
  input  logic [31:0]      dq_vpn,
  output logic             dq_hit,
  output logic             dq_miss,
  output logic             dq_mhit,
  output logic [IDX_W-1:0] dq_idx,
  input  logic             iq_req,
  input  logic [31:0]      iq_vpn,
  output logic             iq_hit,
  output logic             iq_miss,
  output logic             iq_mhit,
  output logic [IDX_W-1:0] iq_idx
);
  import xlat_pkg::*;

  localparam int N = 1 << IDX_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  // staging registers
  logic [31:0] stg_hi, stg_lo;
  logic [3:0]  stg_attr;
  logic [7:0]  cur_asid;
  assign cur_asid = stg_hi[7:0];

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      stg_hi   <= '0;
      stg_lo   <= '0;
      stg_attr <= '0;
    end else if (stg_we) begin
      case (stg_sel)
        2'd0:    stg_hi   <= stg_wdata & 32'hFFFFFCFF;
        2'd1:    stg_lo   <= stg_wdata & 32'h1FFFFDFF;
        2'd2:    stg_attr <= stg_wdata[3:0];
        default: ;
      endcase
    end
  end

  // control fields
  logic [IDX_W-1:0] ptr, bound;
  logic [5:0]       itlb_st;
  logic             inval;
  logic [1:0]       adv;

  assign inval = ctl_we && ctl_wdata[CTL_INV];
  assign adv   = {1'b0, dq_req} + {1'b0, iq_req};

  xlat_repl_ptr #(.IW(IDX_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_s),
    .ld_en  (ctl_we),
    .ld_val (ctl_wdata[10 +: IDX_W]),
    .bound  (bound),
    .adv    (adv),
    .ptr    (ptr)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      bound   <= '0;
      itlb_st <= '0;
    end else if (ctl_we) begin
      bound   <= ctl_wdata[18 +: IDX_W];
      itlb_st <= ctl_wdata[31:26];
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) itlb_flush <= 1'b0;
    else        itlb_flush <= inval;
  end

  always_comb begin
    ctl_rdata            = '0;
    ctl_rdata[10 +: IDX_W] = ptr;
    ctl_rdata[18 +: IDX_W] = bound;
    ctl_rdata[31:26]     = itlb_st;
  end

  // entry array
  tlb_ent_t [N-1:0] ents, ents_n;
  logic [N-1:0]     vld;
  logic [IDX_W-1:0] widx;
  logic             is_assoc;
  logic [N-1:0]     aw_hits;
  logic [IDX_W-1:0] aw_idx;
  logic             aw_any, aw_multi, aw_mhit_n;

  assign widx     = arr_addr[8 +: IDX_W];
  assign is_assoc = arr_we && !arr_data_sel && arr_addr[7];

  for (genvar i = 0; i < N; i++) begin : g_vld
    assign vld[i] = ents[i].flags[FL_VALID];
  end

  xlat_cam_match #(.N(N)) u_aw_match (
    .ents (ents),
    .vpn  (arr_wdata),
    .asid (cur_asid),
    .hits (aw_hits)
  );

  xlat_hit_enc #(.N(N), .IW(IDX_W)) u_aw_enc (
    .hits  (aw_hits),
    .idx   (aw_idx),
    .any   (aw_any),
    .multi (aw_multi)
  );

  always_comb begin
    ents_n    = ents;
    aw_mhit_n = 1'b0;
    if (inval) begin
      for (int i = 0; i < N; i++) ents_n[i].flags[FL_VALID] = 1'b0;
    end else if (load_cmd) begin
      ents_n[ptr].vpn   = stg_hi[31:10];
      ents_n[ptr].asid  = stg_hi[7:0];
      ents_n[ptr].ppn   = stg_lo[28:10];
      ents_n[ptr].flags = stg_lo[8:0];
      ents_n[ptr].attr  = stg_attr;
    end else if (arr_we) begin
      if (arr_data_sel) begin
        if (arr_addr[23]) begin
          ents_n[widx].attr = arr_wdata[3:0];
        end else begin
          ents_n[widx].ppn   = arr_wdata[28:10];
          ents_n[widx].flags = arr_wdata[8:0];
        end
      end else if (arr_addr[7]) begin
        aw_mhit_n = aw_multi;
        if (aw_any && !aw_multi) begin
          ents_n[aw_idx].flags[FL_VALID] = arr_wdata[8];
          ents_n[aw_idx].flags[FL_DIRTY] = arr_wdata[9];
        end
      end else begin
        ents_n[widx].vpn             = arr_wdata[31:10];
        ents_n[widx].asid            = arr_wdata[7:0];
        ents_n[widx].flags[FL_VALID] = arr_wdata[8];
        ents_n[widx].flags[FL_DIRTY] = arr_wdata[9];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ents       <= '0;
      assoc_mhit <= 1'b0;
    end else begin
      ents       <= ents_n;
      assoc_mhit <= aw_mhit_n;
    end
  end

  // array readback
  tlb_ent_t    rd_ent;
  logic [31:0] rd_n;
  always_comb begin
    rd_ent = ents[widx];
    if (arr_data_sel) begin
      if (arr_addr[23]) rd_n = {28'd0, rd_ent.attr};
      else              rd_n = {3'd0, rd_ent.ppn, 1'b0, rd_ent.flags};
    end else begin
      rd_n = {rd_ent.vpn, rd_ent.flags[FL_DIRTY], rd_ent.flags[FL_VALID], rd_ent.asid};
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      arr_rdata <= '0;
    else if (arr_re) arr_rdata <= rd_n;
  end

  // lookup ports: 0 = data, 1 = instruction refill
  logic [1:0]       lk_req;
  logic [1:0][31:0] lk_vpn;
  assign lk_req = {iq_req, dq_req};
  assign lk_vpn = {iq_vpn, dq_vpn};

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [N-1:0]     hv;
    logic [IDX_W-1:0] e_idx, r_idx;
    logic             e_any, e_multi;
    logic             hit_n, miss_n, mhit_n;
    logic             r_hit, r_miss, r_mhit;

    xlat_cam_match #(.N(N)) u_match (
      .ents (ents),
      .vpn  (lk_vpn[p]),
      .asid (cur_asid),
      .hits (hv)
    );

    xlat_hit_enc #(.N(N), .IW(IDX_W)) u_enc (
      .hits  (hv),
      .idx   (e_idx),
      .any   (e_any),
      .multi (e_multi)
    );

    always_comb begin
      hit_n  = lk_req[p] && e_any && !e_multi;
      miss_n = lk_req[p] && !e_any;
      mhit_n = lk_req[p] && e_multi;
    end

    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) begin
        r_hit  <= 1'b0;
        r_miss <= 1'b0;
        r_mhit <= 1'b0;
        r_idx  <= '0;
      end else begin
        r_hit  <= hit_n;
        r_miss <= miss_n;
        r_mhit <= mhit_n;
        if (lk_req[p]) r_idx <= e_idx;
      end
    end

    // R7
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_s)
      lk_req[p] |=> ($countones({r_hit, r_miss, r_mhit}) == 1));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
      !lk_req[p] |=> !(r_hit || r_miss || r_mhit));
  end

  assign dq_hit  = g_port[0].r_hit;
  assign dq_miss = g_port[0].r_miss;
  assign dq_mhit = g_port[0].r_mhit;
  assign dq_idx  = g_port[0].r_idx;
  assign iq_hit  = g_port[1].r_hit;
  assign iq_miss = g_port[1].r_miss;
  assign iq_mhit = g_port[1].r_mhit;
  assign iq_idx  = g_port[1].r_idx;

  // R3
  inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_s)
    inval |=> (vld == '0) && itlb_flush);

  // R4
  load_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (load_cmd && !ctl_we && !dq_req && !iq_req) |=> $stable(ptr));

  // R13
  assoc_multi_frozen_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (is_assoc && aw_multi && !ctl_we && !load_cmd) |=> ($stable(vld) && assoc_mhit));

endmodule

// File: tb/test_xlat_utlb.sv
module test_xlat_utlb;

  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [31:0]   ctl_wdata = '0;
  logic [31:0]   ctl_rdata;
  logic          itlb_flush;
  logic          stg_we = 1'b0;
  logic [1:0]    stg_sel = '0;
  logic [31:0]   stg_wdata = '0;
  logic          load_cmd = 1'b0;
  logic          arr_we = 1'b0;
  logic          arr_re = 1'b0;
  logic          arr_data_sel = 1'b0;
  logic [31:0]   arr_addr = '0;
  logic [31:0]   arr_wdata = '0;
  logic [31:0]   arr_rdata;
  logic          assoc_mhit;
  logic          dq_req = 1'b0;
  logic [31:0]   dq_vpn = '0;
  logic          dq_hit, dq_miss, dq_mhit;
  logic [IW-1:0] dq_idx;
  logic          iq_req = 1'b0;
  logic [31:0]   iq_vpn = '0;
  logic          iq_hit, iq_miss, iq_mhit;
  logic [IW-1:0] iq_idx;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  xlat_utlb #(.IDX_W(IW)) i_xlat_utlb (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .itlb_flush(itlb_flush),
    .stg_we(stg_we), .stg_sel(stg_sel), .stg_wdata(stg_wdata), .load_cmd(load_cmd),
    .arr_we(arr_we), .arr_re(arr_re), .arr_data_sel(arr_data_sel), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .assoc_mhit(assoc_mhit),
    .dq_req(dq_req), .dq_vpn(dq_vpn), .dq_hit(dq_hit), .dq_miss(dq_miss),
    .dq_mhit(dq_mhit), .dq_idx(dq_idx),
    .iq_req(iq_req), .iq_vpn(iq_vpn), .iq_hit(iq_hit), .iq_miss(iq_miss),
    .iq_mhit(iq_mhit), .iq_idx(iq_idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctlw(input int p, input int b, input int it, input bit inv);
    return (32'(it) << 26) | (32'(b) << 18) | (32'(p) << 10) | (32'(inv) << 2);
  endfunction

  // result code: {mhit, miss, hit}
  function automatic logic [2:0] dres();
    return {dq_mhit, dq_miss, dq_hit};
  endfunction
  function automatic logic [2:0] ires();
    return {iq_mhit, iq_miss, iq_hit};
  endfunction

  task automatic ctl_write(input logic [31:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic stage(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); stg_we = 1'b1; stg_sel = sel; stg_wdata = d;
    @(negedge clk); stg_we = 1'b0;
  endtask

  task automatic do_load();
    @(negedge clk); load_cmd = 1'b1;
    @(negedge clk); load_cmd = 1'b0;
  endtask

  task automatic awrite(input bit dsel, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); arr_we = 1'b1; arr_data_sel = dsel; arr_addr = a; arr_wdata = d;
    @(negedge clk); arr_we = 1'b0;
  endtask

  task automatic aread(input bit dsel, input logic [31:0] a);
    @(negedge clk); arr_re = 1'b1; arr_data_sel = dsel; arr_addr = a;
    @(negedge clk); arr_re = 1'b0;
  endtask

  task automatic look(input bit dq, input logic [31:0] dv, input bit iq, input logic [31:0] iv);
    @(negedge clk); dq_req = dq; dq_vpn = dv; iq_req = iq; iq_vpn = iv;
    @(negedge clk); dq_req = 1'b0; iq_req = 1'b0;
  endtask

  task automatic put_entry(input int slot, input logic [31:0] aw, input logic [31:0] dw);
    awrite(1'b0, 32'(slot) << 8, aw);
    awrite(1'b1, 32'(slot) << 8, dw);
  endtask

  task automatic t_reset();
    check("R1 ctl_rdata", ctl_rdata, 32'h0);
    check("R1 data result", {29'd0, dres()}, 32'h0);
    check("R1 instr result", {29'd0, ires()}, 32'h0);
    check("R1 arr_rdata", arr_rdata, 32'h0);
    check("R1 flush", {31'd0, itlb_flush}, 32'h0);
    aread(1'b0, 32'h0000_0500);
    check("R1 slot5 invalid", arr_rdata, 32'h0);
  endtask

  task automatic t_ctl();
    ctl_write(ctlw(5, 9, 6'h2A, 1'b0) | 32'h0000_0003);
    check("R2 ctl readback", ctl_rdata, ctlw(5, 9, 6'h2A, 1'b0));
    check("R2 no flush without bit2", {31'd0, itlb_flush}, 32'h0);
  endtask

  task automatic t_load();
    ctl_write(ctlw(3, 0, 0, 1'b0));
    stage(2'd0, 32'hABCDE7FF);
    stage(2'd1, 32'hFFFFF3FF);
    stage(2'd2, 32'h000000F7);
    do_load();
    check("R4 ptr unchanged by load", ctl_rdata, ctlw(3, 0, 0, 1'b0));
    aread(1'b0, 32'h0000_0300);
    check("R4 loaded address half", arr_rdata, 32'hABCDE7FF);
    aread(1'b1, 32'h0000_0300);
    check("R4 loaded data half", arr_rdata, 32'h1FFFF1FF);
    aread(1'b1, 32'h0080_0300);
    check("R4 loaded attribute", arr_rdata, 32'h7);
  endtask

  task automatic t_lookup();
    stage(2'd0, 32'h0000_0005);
    put_entry(10, 32'h40000105, 32'h0C000110);
    put_entry(11, 32'h50000133, 32'h00000192);
    put_entry(12, 32'h60000506, 32'h00000100);
    aread(1'b0, 32'h0000_0A00);
    check("R5 direct address write", arr_rdata, 32'h40000105);
    look(1'b1, 32'h40000FFC, 1'b0, 32'h0);
    check("R7 hit code", {29'd0, dres()}, 32'h1);
    check("R7 hit index", {26'd0, dq_idx}, 32'd10);
    look(1'b1, 32'h40001000, 1'b0, 32'h0);
    check("R8 4K page boundary miss", {29'd0, dres()}, 32'h2);
    look(1'b0, 32'h0, 1'b1, 32'h40000800);
    check("R11 refill port hit", {29'd0, ires()}, 32'h1);
    check("R11 refill port index", {26'd0, iq_idx}, 32'd10);
    stage(2'd0, 32'h0000_0006);
    look(1'b1, 32'h40000000, 1'b0, 32'h0);
    check("R7 other ASID misses", {29'd0, dres()}, 32'h2);
    look(1'b1, 32'h500FFFFC, 1'b0, 32'h0);
    check("R7 shared 1M hit", {29'd0, dres()}, 32'h1);
    check("R8 1M index", {26'd0, dq_idx}, 32'd11);
    look(1'b1, 32'h50100000, 1'b0, 32'h0);
    check("R8 1M boundary miss", {29'd0, dres()}, 32'h2);
    look(1'b1, 32'h600007FC, 1'b0, 32'h0);
    check("R8 1K hit", {29'd0, dres()}, 32'h1);
    look(1'b1, 32'h60000000, 1'b0, 32'h0);
    check("R8 1K neighbour miss", {29'd0, dres()}, 32'h2);
  endtask

  task automatic t_multi();
    put_entry(20, 32'h70000106, 32'h00000110);
    put_entry(21, 32'h70000106, 32'h00000110);
    look(1'b1, 32'h70000000, 1'b1, 32'h60000400);
    check("R9 data multi-hit", {29'd0, dres()}, 32'h4);
    check("R11 concurrent refill hit", {29'd0, ires()}, 32'h1);
    check("R11 concurrent refill index", {26'd0, iq_idx}, 32'd12);
  endtask

  task automatic t_ptr();
    ctl_write(ctlw(5, 7, 0, 1'b0));
    look(1'b1, 32'h0, 1'b0, 32'h0);
    check("R10 step", ctl_rdata, ctlw(6, 7, 0, 1'b0));
    look(1'b0, 32'h0, 1'b1, 32'h0);
    check("R10 wrap at boundary", ctl_rdata, ctlw(0, 7, 0, 1'b0));
    ctl_write(ctlw(62, 0, 0, 1'b0));
    look(1'b1, 32'h0, 1'b0, 32'h0);
    check("R10 step to 63", ctl_rdata, ctlw(63, 0, 0, 1'b0));
    look(1'b1, 32'h0, 1'b0, 32'h0);
    check("R10 wrap at entry count", ctl_rdata, ctlw(0, 0, 0, 1'b0));
    ctl_write(ctlw(4, 6, 0, 1'b0));
    look(1'b1, 32'h0, 1'b1, 32'h0);
    check("R11 dual advance with wrap", ctl_rdata, ctlw(0, 6, 0, 1'b0));
    ctl_write(ctlw(10, 0, 0, 1'b0));
    look(1'b1, 32'h0, 1'b1, 32'h0);
    check("R11 dual advance by two", ctl_rdata, ctlw(12, 0, 0, 1'b0));
  endtask

  task automatic t_assoc();
    awrite(1'b0, 32'h0000_0080, 32'h60000600);
    check("R12 no mhit pulse", {31'd0, assoc_mhit}, 32'h0);
    aread(1'b0, 32'h0000_0C00);
    check("R12 assoc update", arr_rdata, 32'h60000606);
    look(1'b1, 32'h60000400, 1'b0, 32'h0);
    check("R12 invalidated entry misses", {29'd0, dres()}, 32'h2);
    awrite(1'b0, 32'h0000_0080, 32'h40000000);
    aread(1'b0, 32'h0000_0A00);
    check("R12 no match leaves entry", arr_rdata, 32'h40000105);
    awrite(1'b0, 32'h0000_0080, 32'h70000000);
    check("R13 assoc multi-hit pulse", {31'd0, assoc_mhit}, 32'h1);
    aread(1'b0, 32'h0000_1400);
    check("R13 entry 20 unchanged", arr_rdata, 32'h70000106);
    check("R13 pulse ends", {31'd0, assoc_mhit}, 32'h0);
  endtask

  task automatic t_data();
    awrite(1'b1, 32'h0080_0A00, 32'hFFFFFFF9);
    aread(1'b1, 32'h0080_0A00);
    check("R6 attribute write", arr_rdata, 32'h9);
    aread(1'b1, 32'h0000_0A00);
    check("R6 data word untouched", arr_rdata, 32'h0C000110);
  endtask

  task automatic t_inval();
    stage(2'd0, 32'h0000_0005);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = ctlw(1, 2, 6'h15, 1'b1);
    @(negedge clk); ctl_we = 1'b0;
    check("R3 flush pulse", {31'd0, itlb_flush}, 32'h1);
    check("R2 fields loaded with invalidate", ctl_rdata, ctlw(1, 2, 6'h15, 1'b0));
    look(1'b1, 32'h40000000, 1'b0, 32'h0);
    check("R3 lookup misses after invalidate", {29'd0, dres()}, 32'h2);
    check("R3 flush pulse ends", {31'd0, itlb_flush}, 32'h0);
    aread(1'b0, 32'h0000_0A00);
    check("R3 valid cleared", arr_rdata, 32'h40000005);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctl();
    t_load();
    t_lookup();
    t_multi();
    t_ptr();
    t_assoc();
    t_data();
    t_inval();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule